// File: doc/BRIEF.md
# Accumulator Processor Core with Pixel Output

This block is a small 8-bit processor. It has one accumulator, a bank of index registers, a zero flag, a color register and a return-address stack inside the core. It reads instructions one byte per cycle from a program-memory port. It works on data through a separate RAM port whose read data must come back in the same cycle. The instruction set covers:

- accumulator moves and arithmetic;
- two-register logic that writes its result into the second named register;
- single-register rotate, invert and increment;
- RAM access with the address taken indirectly from a register;
- absolute, indirect and conditional jumps, plus subroutine call and return.

Two instructions serve an external 16-by-16 display. One loads the current color. The other sends a one-cycle pixel-write strobe that carries x and y coordinates and that color.

Every instruction is one opcode byte followed by zero, one or two operand bytes. Each byte takes one cycle to fetch, and one more cycle executes the instruction. A debug instruction parks the core in a halted state. It stays there until the `resume` input is raised, and the `halted` output tells the surrounding system that the core is paused.

Top module: `accu_core`

## Requirements
- R1: While reset is held, and on the first edge after it, `pm_addr` is 0, `halted` is low and neither `ram_we` nor `px_we` is asserted. The accumulator, all index registers, the flag, the color and the stack are cleared.
- R2: Opcode byte values (hex) are: 00 no-op, 01 load-immediate, 02 load-register, 03 exchange, 04 add, 05 subtract, 06 increment, 07 return, 08 indirect jump, 09 RAM fetch, 0A jump, 0B call, 0C compare, 0D jump-if-zero-set, 0E jump-if-zero-clear, 0F RAM store, 10 rotate-right, 11 rotate-left, 12 and, 13 or, 14 invert, 15 xor, 16 debug-halt, 17 set-color, 18 pixel. Operand counts are: none for 00, 07 and 16; two for 09, 0C, 0F, 12, 13 and 15; one for every other listed code. Unlisted codes behave as one-byte no-ops. A register operand names the register with its low 3 bits.
- R3: Load-immediate puts the operand byte in the accumulator. Load-register copies the named register into the accumulator. Exchange swaps the accumulator and the named register in one instruction.
- R4: Add and subtract set the accumulator to accumulator plus or minus the named register, modulo 256. Increment adds one, modulo 256, to the named register.
- R5: AND, OR and XOR combine the first and second named registers and write the result to the second. Invert replaces the named register with its bitwise complement.
- R6: Rotate-right moves bit 0 of the named register into bit 7. Rotate-left moves bit 7 into bit 0.
- R7: Compare sets the zero flag to 1 when the two named registers are equal and to 0 otherwise. No other instruction changes the flag. Jump-if-zero-set and jump-if-zero-clear branch to the operand address according to the flag.
- R8: Jump loads the operand byte into the instruction pointer. Indirect jump loads it from the named register.
- R9: Call pushes the address of the byte after the call onto a 4-entry stack and jumps to the operand address. Return pops the newest entry into the instruction pointer. A fifth unreturned call overwrites the oldest entry, and a return with the stack empty goes to address 0.
- R10: Store writes the second named register to the RAM address held in the first, with `ram_we` high for exactly one cycle. Fetch loads the second named register from RAM at the address held in the first.
- R11: Set-color loads the color register from its operand. Pixel raises `px_we` for one cycle with `px_x` = operand bits 3:0, `px_y` = operand bits 7:4 and `px_color` = the current color.
- R12: No-op leaves the accumulator, registers, flag and RAM untouched and only advances the instruction pointer by one.
- R13: Debug-halt raises `halted` with `pm_addr` just past the halt byte. `pm_addr` holds and no strobe fires until `resume` is sampled high, after which fetching continues from that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pm_addr | output | 8 | Program-memory byte address (instruction pointer) |
| pm_rdata | input | 8 | Program byte at `pm_addr`, same cycle |
| ram_addr | output | 8 | Data-RAM address, taken from the first named register |
| ram_wdata | output | 8 | Data-RAM write value, taken from the second named register |
| ram_we | output | 1 | Data-RAM write strobe |
| ram_rdata | input | 8 | Data-RAM read value at `ram_addr`, same cycle |
| px_we | output | 1 | Pixel-write strobe |
| px_x | output | 4 | Pixel column |
| px_y | output | 4 | Pixel row |
| px_color | output | 8 | Pixel color |
| resume | input | 1 | Releases the core from the debug halt |
| halted | output | 1 | High while the core is paused by the debug instruction |

## Verification
The bench builds the core with its defaults: eight index registers, a four-entry return stack and an 8-bit instruction pointer. With an 8-bit pointer the whole 256-byte program space can be modeled, so each test is a complete generated program with back-patched branch targets. With a four-entry stack, five nested calls are enough to reach the overflow wrap and then the return on an empty stack. A 16-by-16 grid of operand pairs, including equal pairs and the values 00 and FF, runs every arithmetic, logic, rotate, compare-branch and RAM path. Each result is compared with values the bench works out arithmetically.

// File: rtl/accu_pkg.sv
package accu_pkg;
  localparam int DATA_W = 8;

  typedef enum logic [7:0] {
    OP_NOP  = 8'h00, OP_LDI  = 8'h01, OP_LDR  = 8'h02, OP_XCH  = 8'h03,
    OP_ADD  = 8'h04, OP_SUB  = 8'h05, OP_INC  = 8'h06, OP_RET  = 8'h07,
    OP_JIN  = 8'h08, OP_FCH  = 8'h09, OP_JMP  = 8'h0A, OP_CALL = 8'h0B,
    OP_CMP  = 8'h0C, OP_JEQ  = 8'h0D, OP_JNE  = 8'h0E, OP_STR  = 8'h0F,
    OP_ROR  = 8'h10, OP_ROL  = 8'h11, OP_AND  = 8'h12, OP_OR   = 8'h13,
    OP_NOT  = 8'h14, OP_XOR  = 8'h15, OP_DBG  = 8'h16, OP_COLR = 8'h17,
    OP_PIX  = 8'h18
  } opcode_e;

  typedef enum logic [2:0] {ST_OP, ST_A, ST_B, ST_EXEC, ST_HALT} phase_e;

  // Number of operand bytes that follow an opcode byte.
  function automatic logic [1:0] operand_count(input logic [7:0] op);
    case (op)
      OP_NOP, OP_RET, OP_DBG:                       return 2'd0;
      OP_FCH, OP_CMP, OP_STR, OP_AND, OP_OR, OP_XOR: return 2'd2;
      default: return (op <= OP_PIX) ? 2'd1 : 2'd0;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] rot_right(input logic [DATA_W-1:0] v);
    return {v[0], v[DATA_W-1:1]};
  endfunction

  function automatic logic [DATA_W-1:0] rot_left(input logic [DATA_W-1:0] v);
    return {v[DATA_W-2:0], v[DATA_W-1]};
  endfunction
endpackage

// File: rtl/accu_regbank.sv
module accu_regbank #(
  parameter int NREG = 8,
  parameter int W    = 8,
  parameter int AW   = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_a,
  output logic [W-1:0]  rdata_b
);
  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    for (int i = 0; i < NREG; i++) begin
      if (rst)                           regs[i] <= '0;
      else if (we && waddr == AW'(i))    regs[i] <= wdata;
    end
  end

  assign rdata_a = regs[raddr_a];
  assign rdata_b = regs[raddr_b];
endmodule

// File: rtl/accu_retstack.sv
module accu_retstack #(
  parameter int DEPTH = 4,
  parameter int W     = 8,
  parameter int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  push_val,
  output logic [W-1:0]  top_val,
  output logic [CW-1:0] count
);
  logic [W-1:0]  slots [DEPTH];
  logic [PW-1:0] wptr, top_idx, next_idx;

  // Circular pointer; the oldest slot is overwritten on overflow.
  assign next_idx = (wptr == PW'(DEPTH - 1)) ? '0 : wptr + PW'(1);
  assign top_idx  = (wptr == '0) ? PW'(DEPTH - 1) : wptr - PW'(1);
  assign top_val  = (count == '0) ? '0 : slots[top_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      count <= '0;
      for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
    end else if (push) begin
      slots[wptr] <= push_val;
      wptr        <= next_idx;
      if (count != CW'(DEPTH)) count <= count + CW'(1);
    end else if (pop && count != '0) begin
      wptr  <= top_idx;
      count <= count - CW'(1);
    end
  end
endmodule

// File: rtl/accu_alu.sv
module accu_alu
  import accu_pkg::*;
(
  input  logic [7:0]        op,
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] va,
  input  logic [DATA_W-1:0] vb,
  input  logic [DATA_W-1:0] imm,
  input  logic [DATA_W-1:0] mem,
  output logic [DATA_W-1:0] acc_nx,
  output logic [DATA_W-1:0] reg_nx,
  output logic              eq
);
  assign eq = (va == vb);

  always_comb begin
    acc_nx = acc;
    reg_nx = va;
    case (op)
      OP_LDI: acc_nx = imm;
      OP_LDR: acc_nx = va;
      OP_XCH: begin acc_nx = va; reg_nx = acc; end
      OP_ADD: acc_nx = acc + va;
      OP_SUB: acc_nx = acc - va;
      OP_INC: reg_nx = va + DATA_W'(1);
      OP_ROR: reg_nx = rot_right(va);
      OP_ROL: reg_nx = rot_left(va);
      OP_NOT: reg_nx = ~va;
      OP_AND: reg_nx = va & vb;
      OP_OR:  reg_nx = va | vb;
      OP_XOR: reg_nx = va ^ vb;
      OP_FCH: reg_nx = mem;
      default: ;
    endcase
  end
endmodule

// File: rtl/accu_core.sv
module accu_core
  import accu_pkg::*;
#(
  parameter int NREG        = 8,
  parameter int STACK_DEPTH = 4,
  parameter int PC_W        = 8
) (
  input  logic              clk,
  input  logic              rst,
  output logic [PC_W-1:0]   pm_addr,
  input  logic [DATA_W-1:0] pm_rdata,
  output logic [DATA_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  output logic              ram_we,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic              px_we,
  output logic [3:0]        px_x,
  output logic [3:0]        px_y,
  output logic [DATA_W-1:0] px_color,
  input  logic              resume,
  output logic              halted
);
  localparam int RIDX_W = (NREG > 1) ? $clog2(NREG) : 1;
  localparam int CNT_W  = $clog2(STACK_DEPTH + 1);

  phase_e            phase;
  logic [PC_W-1:0]   pc;
  logic [7:0]        ir;
  logic [DATA_W-1:0] opa, opb, acc, color;
  logic              zf;

  // Named internal events, also observed by the bound checker.
  logic              exec, cmp_exec, cmp_eq, reg_we, wr_first, wr_second;
  logic              stk_push, stk_pop;
  logic [PC_W-1:0]   stk_top;
  logic [CNT_W-1:0]  stk_count;
  logic [RIDX_W-1:0] ra, rb;
  logic [DATA_W-1:0] va, vb, acc_nx, reg_nx;

  assign exec     = (phase == ST_EXEC);
  assign cmp_exec = exec && ir == OP_CMP;
  assign stk_push = exec && ir == OP_CALL;
  assign stk_pop  = exec && ir == OP_RET;
  assign ra       = opa[RIDX_W-1:0];
  assign rb       = opb[RIDX_W-1:0];

  always_comb begin
    wr_first  = 1'b0;
    wr_second = 1'b0;
    case (ir)
      OP_XCH, OP_INC, OP_ROR, OP_ROL, OP_NOT: wr_first  = 1'b1;
      OP_AND, OP_OR, OP_XOR, OP_FCH:          wr_second = 1'b1;
      default: ;
    endcase
  end
  assign reg_we = exec && (wr_first || wr_second);

  accu_regbank #(.NREG(NREG), .W(DATA_W), .AW(RIDX_W)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .waddr(wr_second ? rb : ra),
    .wdata(reg_nx), .raddr_a(ra), .raddr_b(rb), .rdata_a(va), .rdata_b(vb)
  );

  accu_retstack #(.DEPTH(STACK_DEPTH), .W(PC_W)) u_stack (
    .clk(clk), .rst(rst), .push(stk_push), .pop(stk_pop), .push_val(pc),
    .top_val(stk_top), .count(stk_count)
  );

  accu_alu u_alu (
    .op(ir), .acc(acc), .va(va), .vb(vb), .imm(opa), .mem(ram_rdata),
    .acc_nx(acc_nx), .reg_nx(reg_nx), .eq(cmp_eq)
  );

  // Fetch / operand / execute sequencer.
  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= ST_OP;
      pc    <= '0;
      ir    <= '0;
      opa   <= '0;
      opb   <= '0;
      acc   <= '0;
      zf    <= 1'b0;
      color <= '0;
    end else begin
      case (phase)
        ST_OP: begin
          ir    <= pm_rdata;
          pc    <= pc + PC_W'(1);
          phase <= (operand_count(pm_rdata) == 2'd0) ? ST_EXEC : ST_A;
        end
        ST_A: begin
          opa   <= pm_rdata;
          pc    <= pc + PC_W'(1);
          phase <= (operand_count(ir) == 2'd2) ? ST_B : ST_EXEC;
        end
        ST_B: begin
          opb   <= pm_rdata;
          pc    <= pc + PC_W'(1);
          phase <= ST_EXEC;
        end
        ST_EXEC: begin
          acc   <= acc_nx;
          phase <= (ir == OP_DBG) ? ST_HALT : ST_OP;
          if (cmp_exec)        zf    <= cmp_eq;
          if (ir == OP_COLR)   color <= opa;
          case (ir)
            OP_JMP, OP_CALL: pc <= PC_W'(opa);
            OP_JEQ: if (zf)  pc <= PC_W'(opa);
            OP_JNE: if (!zf) pc <= PC_W'(opa);
            OP_JIN:          pc <= PC_W'(va);
            OP_RET:          pc <= stk_top;
            default: ;
          endcase
        end
        ST_HALT: if (resume) phase <= ST_OP;
        default: phase <= ST_OP;
      endcase
    end
  end

  assign pm_addr   = pc;
  assign halted    = (phase == ST_HALT);
  assign ram_addr  = va;
  assign ram_wdata = vb;
  assign ram_we    = exec && ir == OP_STR;
  assign px_we     = exec && ir == OP_PIX;
  assign px_x      = opa[3:0];
  assign px_y      = opa[7:4];
  assign px_color  = color;
endmodule

// File: rtl/accu_core_chk.sv
module accu_core_chk #(
  parameter int PC_W        = 8,
  parameter int STACK_DEPTH = 4
) (
  input logic                               clk,
  input logic                               rst,
  input logic [PC_W-1:0]                    pm_addr,
  input logic                               halted,
  input logic                               resume,
  input logic                               ram_we,
  input logic                               px_we,
  input logic                               zf,
  input logic                               cmp_exec,
  input logic                               cmp_eq,
  input logic [$clog2(STACK_DEPTH+1)-1:0]   stk_count
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (pm_addr == '0 && !halted && !ram_we && !px_we));

  assert_flag_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !cmp_exec |=> $stable(zf));

  assert_flag_load_R7: assert property (@(posedge clk) disable iff (rst)
    cmp_exec |=> (zf == $past(cmp_eq)));

  assert_stack_bound_R9: assert property (@(posedge clk) disable iff (rst)
    stk_count <= ($clog2(STACK_DEPTH+1))'(STACK_DEPTH));

  assert_store_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    ram_we |=> !ram_we);

  assert_strobe_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
    !(ram_we && px_we));

  assert_pixel_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    px_we |=> !px_we);

  assert_halt_hold_R13: assert property (@(posedge clk) disable iff (rst)
    (halted && !resume) |=> (halted && $stable(pm_addr)));

  assert_halt_quiet_R13: assert property (@(posedge clk) disable iff (rst)
    halted |-> (!ram_we && !px_we));
endmodule

bind accu_core accu_core_chk #(.PC_W(PC_W), .STACK_DEPTH(STACK_DEPTH)) u_chk (
  .clk(clk), .rst(rst), .pm_addr(pm_addr), .halted(halted), .resume(resume),
  .ram_we(ram_we), .px_we(px_we), .zf(zf), .cmp_exec(cmp_exec),
  .cmp_eq(cmp_eq), .stk_count(stk_count)
);

// File: tb/sim_accu_core.sv
`timescale 1ns/1ps
module sim_accu_core;
  // Opcode values restated from R2.
  localparam logic [7:0] C_NOP = 8'h00, C_LDI = 8'h01, C_LDR = 8'h02, C_XCH = 8'h03,
    C_ADD = 8'h04, C_SUB = 8'h05, C_INC = 8'h06, C_RET = 8'h07, C_JIN = 8'h08,
    C_FCH = 8'h09, C_JMP = 8'h0A, C_CALL = 8'h0B, C_CMP = 8'h0C, C_JEQ = 8'h0D,
    C_JNE = 8'h0E, C_STR = 8'h0F, C_ROR = 8'h10, C_ROL = 8'h11, C_AND = 8'h12,
    C_OR = 8'h13, C_NOT = 8'h14, C_XOR = 8'h15, C_DBG = 8'h16, C_COLR = 8'h17,
    C_PIX = 8'h18;

  logic clk = 1'b0, rst = 1'b1, resume = 1'b0;
  logic [7:0] pm_addr, pm_rdata, ram_addr, ram_wdata, ram_rdata, px_color;
  logic ram_we, px_we, halted;
  logic [3:0] px_x, px_y;

  logic [7:0] pm  [256];
  logic [7:0] ram [256];
  logic [15:0] px_log [4];
  int px_n, wp;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  accu_core u0 (
    .clk(clk), .rst(rst), .pm_addr(pm_addr), .pm_rdata(pm_rdata),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_we(ram_we), .ram_rdata(ram_rdata),
    .px_we(px_we), .px_x(px_x), .px_y(px_y), .px_color(px_color),
    .resume(resume), .halted(halted)
  );

  assign pm_rdata  = pm[pm_addr];
  assign ram_rdata = ram[ram_addr];

  always @(posedge clk) if (ram_we) ram[ram_addr] <= ram_wdata;

  always @(negedge clk) if (px_we) begin
    if (px_n < 4) px_log[px_n] = {px_y, px_x, px_color};
    px_n = px_n + 1;
  end

  task automatic chk(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic e1(input logic [7:0] b);
    pm[wp[7:0]] = b;
    wp++;
  endtask
  task automatic e2(input logic [7:0] op, input logic [7:0] x);
    e1(op); e1(x);
  endtask
  task automatic e3(input logic [7:0] op, input logic [7:0] x, input logic [7:0] y);
    e1(op); e1(x); e1(y);
  endtask
  task automatic copy_reg(input logic [7:0] rs, input logic [7:0] rd);
    e2(C_LDR, rs); e2(C_XCH, rd);
  endtask
  task automatic store_reg(input logic [7:0] addr, input logic [7:0] r);
    e2(C_LDI, addr); e2(C_XCH, 8'd0); e3(C_STR, 8'd0, r);
  endtask
  task automatic store_acc(input logic [7:0] addr);
    e2(C_XCH, 8'd3); store_reg(addr, 8'd3);
  endtask
  task automatic new_prog();
    for (int i = 0; i < 256; i++) pm[i] = C_NOP;
    wp = 0;
  endtask

  task automatic wait_halt(input string tag);
    int n = 0;
    while (!halted && n < 6000) begin @(negedge clk); n++; end
    if (!halted) begin
      checks++; fails++;
      $display("FAIL %s: actual running expected halted", tag);
    end
  endtask

  task automatic run_prog(input string tag);
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < 256; i++) ram[i] = 8'h00;
    px_n = 0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    wait_halt(tag);
  endtask

  // Watchdog: counts as a failed check and still prints the summary.
  initial begin
    repeat (190000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int a, b, p, q, c;
    int fstart [6];
    int cpos [6];
    new_prog();

    // R1: reset state at the ports.
    repeat (2) @(negedge clk);
    chk("R1", "pm_addr in reset", int'(pm_addr), 0);
    chk("R1", "halted in reset", int'(halted), 0);
    chk("R1", "strobes in reset", int'({ram_we, px_we}), 0);

    // R3..R8, R10: grid of operand pairs.
    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 16; j++) begin
        a = (i == 15) ? 255 : (i * 37 + 5) % 256;
        b = (j == 0) ? a : ((j == 15) ? 0 : (j * 59 + i * 3) % 256);
        new_prog();
        e2(C_LDI, 8'(a)); e2(C_XCH, 8'd1); e2(C_LDI, 8'(b)); e2(C_XCH, 8'd2);
        e2(C_LDR, 8'd1); e2(C_ADD, 8'd2); store_acc(8'h10);
        e2(C_LDR, 8'd1); e2(C_SUB, 8'd2); store_acc(8'h11);
        copy_reg(8'd2, 8'd5); e3(C_AND, 8'd1, 8'd5); store_reg(8'h12, 8'd5);
        copy_reg(8'd2, 8'd5); e3(C_OR,  8'd1, 8'd5); store_reg(8'h13, 8'd5);
        copy_reg(8'd2, 8'd5); e3(C_XOR, 8'd1, 8'd5); store_reg(8'h14, 8'd5);
        copy_reg(8'd1, 8'd5); e2(C_NOT, 8'd5); store_reg(8'h15, 8'd5);
        copy_reg(8'd1, 8'd5); e2(C_ROR, 8'd5); store_reg(8'h16, 8'd5);
        copy_reg(8'd1, 8'd5); e2(C_ROL, 8'd5); store_reg(8'h17, 8'd5);
        copy_reg(8'd1, 8'd5); e2(C_INC, 8'd5); store_reg(8'h18, 8'd5);
        e3(C_CMP, 8'd1, 8'd2);
        p = wp; e2(C_JEQ, 8'd0); e2(C_LDI, 8'hAA);
        q = wp; e2(C_JMP, 8'd0); pm[p + 1] = 8'(wp); e2(C_LDI, 8'h55);
        pm[q + 1] = 8'(wp); store_acc(8'h19);
        p = wp; e2(C_JNE, 8'd0); e2(C_LDI, 8'h33);
        q = wp; e2(C_JMP, 8'd0); pm[p + 1] = 8'(wp); e2(C_LDI, 8'hCC);
        pm[q + 1] = 8'(wp); store_acc(8'h1A);
        e2(C_LDI, 8'h10); e2(C_XCH, 8'd0); e3(C_FCH, 8'd0, 8'd6); store_reg(8'h1B, 8'd6);
        e2(C_LDR, 8'd2); e2(C_XCH, 8'd1); store_acc(8'h1C);
        e2(C_LDR, 8'd1); store_acc(8'h1D);
        e1(C_DBG);
        run_prog("grid");
        chk("R4", "add", int'(ram[8'h10]), (a + b) % 256);
        chk("R4", "sub", int'(ram[8'h11]), (a - b + 256) % 256);
        chk("R5", "and", int'(ram[8'h12]), a & b);
        chk("R5", "or",  int'(ram[8'h13]), a | b);
        chk("R5", "xor", int'(ram[8'h14]), a ^ b);
        chk("R5", "not", int'(ram[8'h15]), 255 - a);
        chk("R6", "ror", int'(ram[8'h16]), ((a >> 1) | (a << 7)) & 255);
        chk("R6", "rol", int'(ram[8'h17]), ((a << 1) | (a >> 7)) & 255);
        chk("R4", "inc", int'(ram[8'h18]), (a + 1) % 256);
        chk("R7", "jump-if-zero-set", int'(ram[8'h19]), (a == b) ? 8'h55 : 8'hAA);
        chk("R7", "jump-if-zero-clear", int'(ram[8'h1A]), (a != b) ? 8'hCC : 8'h33);
        chk("R10", "fetch", int'(ram[8'h1B]), (a + b) % 256);
        chk("R3", "exchange acc", int'(ram[8'h1C]), a);
        chk("R3", "exchange reg", int'(ram[8'h1D]), b);
      end
    end

    // R9: five nested calls overflow the stack; final return on empty goes to 0.
    new_prog();
    e2(C_INC, 8'd7); e2(C_LDI, 8'd2); e2(C_XCH, 8'd6); e3(C_CMP, 8'd6, 8'd7);
    p = wp; e2(C_JEQ, 8'd0);
    c = wp; e2(C_CALL, 8'd0); e2(C_LDI, 8'hEE); store_acc(8'h3F); e1(C_DBG);
    pm[p + 1] = 8'(wp); e1(C_DBG);
    for (int k = 1; k <= 5; k++) begin
      fstart[k] = wp;
      if (k < 5) begin cpos[k] = wp; e2(C_CALL, 8'd0); end
      e2(C_LDI, 8'(k)); store_acc(8'(8'h30 + k)); e1(C_RET);
    end
    for (int k = 1; k <= 4; k++) pm[cpos[k] + 1] = 8'(fstart[k + 1]);
    pm[c + 1] = 8'(fstart[1]);
    run_prog("R9 stack");
    for (int k = 1; k <= 5; k++) chk("R9", "return order marker", int'(ram[8'(8'h30 + k)]), k);
    chk("R9", "oldest return overwritten", int'(ram[8'h3F]), 0);

    // R8: indirect jump skips the code in between.
    new_prog();
    p = wp; e2(C_LDI, 8'd0); e2(C_XCH, 8'd2); e2(C_JIN, 8'd2);
    e2(C_LDI, 8'hBB); store_acc(8'h40);
    pm[p + 1] = 8'(wp); e2(C_LDI, 8'h77); store_acc(8'h41); e1(C_DBG);
    run_prog("R8 jin");
    chk("R8", "skipped store", int'(ram[8'h40]), 0);
    chk("R8", "target store", int'(ram[8'h41]), 8'h77);

    // R12: no-ops keep the accumulator and advance by one byte each.
    new_prog();
    e2(C_LDI, 8'h3C); e1(C_NOP); e1(C_NOP); e1(8'hE5); store_acc(8'h50); e1(C_DBG);
    run_prog("R12 nop");
    chk("R12", "acc kept across no-ops", int'(ram[8'h50]), 8'h3C);
    chk("R12", "halt address", int'(pm_addr), 2 + 3 + 9 + 1);

    // R11: color and pixel strobes.
    new_prog();
    e2(C_COLR, 8'h9C); e2(C_PIX, 8'h5A); e2(C_COLR, 8'h21); e2(C_PIX, 8'hF0); e1(C_DBG);
    run_prog("R11 pixel");
    chk("R11", "pixel count", px_n, 2);
    chk("R11", "first pixel y,x,color", int'(px_log[0]), 16'h5A9C);
    chk("R11", "second pixel y,x,color", int'(px_log[1]), 16'hF021);

    // R13: halt, hold, resume.
    new_prog();
    e1(C_DBG); e2(C_LDI, 8'h66); store_acc(8'h50); e1(C_DBG);
    run_prog("R13 halt");
    chk("R13", "halted flag", int'(halted), 1);
    chk("R13", "address past halt", int'(pm_addr), 1);
    repeat (20) @(negedge clk);
    chk("R13", "address held", int'(pm_addr), 1);
    chk("R13", "no store while halted", int'(ram[8'h50]), 0);
    resume = 1'b1;
    @(negedge clk);
    resume = 1'b0;
    wait_halt("R13 resume");
    chk("R13", "store after resume", int'(ram[8'h50]), 8'h66);
    chk("R13", "second halt address", int'(pm_addr), 13);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule